// File: doc/BRIEF.md
# Programmable-LUT Butterfly Bit Permuter

This unit transforms a 64-bit word through a chain of up to six butterfly rows. In a plain generalised reverse, each row either swaps every bit with its partner or does nothing. Here, each enabled row instead computes every output bit from a 2-input lookup on the bit and its partner. The partner is the bit whose index differs in the row's chunk bit. An 8-bit immediate supplies two 4-entry tables. One table serves the positions whose chunk bit is clear, and the other serves the positions whose chunk bit is set. The 6-bit shift amount selects which rows run. Rows run in ascending chunk-size order.

The starting word comes from a register operand. When the register select is zero, it is instead a built-in alternating pattern with bit 0 set. An invert flag complements the starting word. Suitable immediates make the unit behave as plain generalised reverse or as generalised OR-combine. Other immediates make it generate the regular mask constants used for byte or halfword movemask extraction. Each result is captured in an output register one cycle after it is requested. Operand decode and register-file access are handled outside the unit.

Top module: `lut_butterfly`

## Requirements
- R1: When `src_sel` is 0, the starting word is 0x5555_5555_5555_5555, whatever `src_val` holds.
- R2: When `src_sel` is non-zero, the starting word is `src_val`. With no row enabled and no invert, the result equals `src_val`.
- R3: When `invert` is 1, the starting word is complemented. A zero select with invert starts from 0xAAAA_AAAA_AAAA_AAAA.
- R4: Row k (k = 0..5) has chunk size 2^k. It runs only when bit k of `shamt` is set. Rows run in order k = 0, 1, ..., 5, each taking the previous row's output.
- R5: Inside a row, a position j with (j & chunk) == 0 outputs imm[{self, partner}], which is an index 0..3 into bits 3:0. A position with the chunk bit set outputs imm[4 + {partner, self}]. Here partner is bit j ^ chunk of the row input.
- R6: Immediate 0xCA acts as plain generalised reverse. `shamt` = 63 fully bit-reverses the word, and `shamt` = 4 swaps the nibbles inside each byte.
- R7: Immediate 0xEE acts as generalised OR-combine. Each enabled row ORs each bit with its partner.
- R8: With zero select, no invert and immediate 0x6C, shift values 2, 6 and 14 give 0x1111_1111_1111_1111, 0x0101_0101_0101_0101 and 0x0001_0001_0001_0001. With invert and immediate 0xC6, the same shifts give 0x8888_8888_8888_8888, 0x8080_8080_8080_8080 and 0x8000_8000_8000_8000.
- R9: Only `shamt[5:0]` has any effect. The upper operand bits are ignored.
- R10: A request with `in_valid` high appears on `result`, with `out_valid` high, after exactly one rising edge. While `in_valid` is low, `out_valid` falls and `result` holds its last value.
- R11: While `rst_n` is low, `out_valid` is 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe: capture a new result |
| src_sel | input | 5 | Register select; zero picks the built-in seed |
| src_val | input | 64 | Register operand value |
| shamt | input | 64 | Shift operand; low 6 bits enable rows |
| imm | input | 8 | Two LUT2 tables: [3:0] low side, [7:4] high side |
| invert | input | 1 | Complement the starting word |
| out_valid | output | 1 | Result register holds a fresh result |
| result | output | 64 | Registered result |

## Verification
The published mask-constant cases are run with immediates 0x6C and 0xC6. They depend on both the row ordering and the asymmetric index convention, so a wrong index order or a wrong row order shows up at once. The 0xCA and 0xEE immediates are tried with a single row, with six rows and with a nibble swap. These cases tell a swap apart from an OR, and a full reverse apart from a partial one. Zero-shift cases with and without a register select and invert isolate the seed path. A shift operand with garbage in its upper bits checks that those bits are ignored. A long stream of pseudo-random operands is then compared with a behavioural model, and an idle cycle with changed inputs confirms that the result holds.

// File: rtl/lbf_pkg.sv
package lbf_pkg;
    localparam int IMM_W = 8;
    localparam int LUT_W = 4;

    typedef logic [LUT_W-1:0] lut2_t;

    // Look up a 2-input table: index is {msb_in, lsb_in}
    function automatic logic lut2_eval(input lut2_t tbl, input logic msb_in, input logic lsb_in);
        return tbl[{msb_in, lsb_in}];
    endfunction
endpackage

// File: rtl/lbf_seed.sv
module lbf_seed #(
    parameter int XLEN  = 64,
    parameter int SEL_W = 5
) (
    input  logic [SEL_W-1:0] src_sel,
    input  logic [XLEN-1:0]  src_val,
    input  logic             invert,
    output logic [XLEN-1:0]  seed
);
    localparam logic [XLEN-1:0] ALT_CONST = {(XLEN/2){2'b01}};

    logic [XLEN-1:0] base;

    always_comb begin
        base = (src_sel == '0) ? ALT_CONST : src_val;
        seed = invert ? ~base : base;
    end
endmodule

// File: rtl/lbf_stage.sv
module lbf_stage
    import lbf_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int CHUNK = 1
) (
    input  logic             en,
    input  logic [IMM_W-1:0] imm,
    input  logic [XLEN-1:0]  din,
    output logic [XLEN-1:0]  dout
);
    lut2_t lo_tbl;
    lut2_t hi_tbl;

    assign lo_tbl = imm[LUT_W-1:0];
    assign hi_tbl = imm[IMM_W-1:LUT_W];

    for (genvar j = 0; j < XLEN; j++) begin : g_bit
        localparam int PART = j ^ CHUNK;
        logic f;
        if ((j & CHUNK) == 0) begin : g_lo
            assign f = lut2_eval(lo_tbl, din[j], din[PART]);
        end else begin : g_hi
            assign f = lut2_eval(hi_tbl, din[PART], din[j]);
        end
        assign dout[j] = en ? f : din[j];
    end
endmodule

// File: rtl/lbf_network.sv
module lbf_network
    import lbf_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]         seed,
    input  logic [$clog2(XLEN)-1:0] row_en,
    input  logic [IMM_W-1:0]        imm,
    output logic [XLEN-1:0]         dout
);
    localparam int ROWS = $clog2(XLEN);

    logic [XLEN-1:0] chain [ROWS+1];

    assign chain[0] = seed;

    for (genvar k = 0; k < ROWS; k++) begin : g_row
        lbf_stage #(
            .XLEN (XLEN),
            .CHUNK(1 << k)
        ) u_stage (
            .en  (row_en[k]),
            .imm (imm),
            .din (chain[k]),
            .dout(chain[k+1])
        );
    end

    assign dout = chain[ROWS];
endmodule

// File: rtl/lut_butterfly.sv
module lut_butterfly
    import lbf_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int SEL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [SEL_W-1:0] src_sel,
    input  logic [XLEN-1:0]  src_val,
    input  logic [XLEN-1:0]  shamt,
    input  logic [IMM_W-1:0] imm,
    input  logic             invert,
    output logic             out_valid,
    output logic [XLEN-1:0]  result
);
    localparam int ROWS = $clog2(XLEN);

    logic [XLEN-1:0] seed_w;
    logic [XLEN-1:0] net_w;

    lbf_seed #(
        .XLEN (XLEN),
        .SEL_W(SEL_W)
    ) u_seed (
        .src_sel(src_sel),
        .src_val(src_val),
        .invert (invert),
        .seed   (seed_w)
    );

    lbf_network #(
        .XLEN(XLEN)
    ) u_net (
        .seed  (seed_w),
        .row_en(shamt[ROWS-1:0]),
        .imm   (imm),
        .dout  (net_w)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= net_w;
            end
        end
    end
endmodule

// File: rtl/lut_butterfly_chk.sv
module lut_butterfly_chk #(
    parameter int XLEN  = 64,
    parameter int SEL_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [SEL_W-1:0] src_sel,
    input logic [XLEN-1:0]  src_val,
    input logic [XLEN-1:0]  shamt,
    input logic [7:0]       imm,
    input logic             invert,
    input logic             out_valid,
    input logic [XLEN-1:0]  result
);
    localparam int SH_W = $clog2(XLEN);
    localparam logic [XLEN-1:0] ALT = {(XLEN/2){2'b01}};

    function automatic logic [XLEN-1:0] rev_bits(input logic [XLEN-1:0] v);
        logic [XLEN-1:0] r;
        for (int i = 0; i < XLEN; i++) r[i] = v[XLEN-1-i];
        return r;
    endfunction

    logic no_rows;
    assign no_rows = (shamt[SH_W-1:0] == '0);

    // R10
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R10
    valid_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    // R1
    seed_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && src_sel == '0 && no_rows && !invert) |=> result == ALT);

    // R2
    seed_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && src_sel != '0 && no_rows && !invert) |=> result == $past(src_val));

    // R3
    seed_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && src_sel != '0 && no_rows && invert) |=> result == ~$past(src_val));

    // R6
    full_reverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && src_sel != '0 && !invert && imm == 8'hCA && shamt[SH_W-1:0] == '1)
        |=> result == rev_bits($past(src_val)));

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == '0));
endmodule

bind lut_butterfly lut_butterfly_chk #(
    .XLEN (XLEN),
    .SEL_W(SEL_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .src_sel  (src_sel),
    .src_val  (src_val),
    .shamt    (shamt),
    .imm      (imm),
    .invert   (invert),
    .out_valid(out_valid),
    .result   (result)
);

// File: tb/lut_butterfly_tb.sv
module lut_butterfly_tb;
    localparam int XLEN = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  src_sel = '0;
    logic [63:0] src_val = '0;
    logic [63:0] shamt = '0;
    logic [7:0]  imm = '0;
    logic        invert = 1'b0;
    logic        out_valid;
    logic [63:0] result;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lut_butterfly u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_sel(src_sel),
        .src_val(src_val), .shamt(shamt), .imm(imm), .invert(invert),
        .out_valid(out_valid), .result(result)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [4:0]  sel;
        logic [63:0] val;
        logic [63:0] sh;
        logic [7:0]  im;
        logic        inv;
        logic [63:0] exp;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        // R8: mask constants, no invert
        '{4'd8, 5'd0, 64'h0, 64'd2,  8'h6C, 1'b0, 64'h1111_1111_1111_1111},
        '{4'd8, 5'd0, 64'h0, 64'd6,  8'h6C, 1'b0, 64'h0101_0101_0101_0101},
        '{4'd8, 5'd0, 64'h0, 64'd14, 8'h6C, 1'b0, 64'h0001_0001_0001_0001},
        // R8: mask constants, inverted seed
        '{4'd8, 5'd0, 64'h0, 64'd2,  8'hC6, 1'b1, 64'h8888_8888_8888_8888},
        '{4'd8, 5'd0, 64'h0, 64'd6,  8'hC6, 1'b1, 64'h8080_8080_8080_8080},
        '{4'd8, 5'd0, 64'h0, 64'd14, 8'hC6, 1'b1, 64'h8000_8000_8000_8000},
        // R1: constant seed ignores src_val
        '{4'd1, 5'd0, 64'hDEAD_BEEF_0000_FFFF, 64'd0, 8'h5A, 1'b0, 64'h5555_5555_5555_5555},
        // R3: inverted constant seed
        '{4'd3, 5'd0, 64'h0, 64'd0, 8'h00, 1'b1, 64'hAAAA_AAAA_AAAA_AAAA},
        // R3: inverted register seed
        '{4'd3, 5'd3, 64'h0123_4567_89AB_CDEF, 64'd0, 8'hFF, 1'b1, 64'hFEDC_BA98_7654_3210},
        // R6: full bit reverse
        '{4'd6, 5'd1, 64'h1, 64'd63, 8'hCA, 1'b0, 64'h8000_0000_0000_0000},
        // R6: nibble swap in bytes
        '{4'd6, 5'd2, 64'h0123_4567_89AB_CDEF, 64'd4, 8'hCA, 1'b0, 64'h1032_5476_98BA_DCFE},
        // R7: OR-combine all rows
        '{4'd7, 5'd1, 64'h1, 64'd63, 8'hEE, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF},
        // R7: OR-combine one row
        '{4'd7, 5'd1, 64'h100, 64'd1, 8'hEE, 1'b0, 64'h300},
        // R9: upper shift bits ignored
        '{4'd9, 5'd0, 64'h0, 64'hFFFF_FFFF_FFFF_FFC2, 8'h6C, 1'b0, 64'h1111_1111_1111_1111}
    };

    // Behavioural model built from R1..R5
    function automatic logic [63:0] model(input logic [4:0] s, input logic [63:0] v,
                                          input logic [63:0] sh, input logic [7:0] im,
                                          input logic inv);
        logic [63:0] x;
        logic [63:0] y;
        x = (s == 0) ? 64'h5555_5555_5555_5555 : v;
        if (inv) x = ~x;
        for (int k = 0; k < 6; k++) begin
            if (sh[k]) begin
                for (int j = 0; j < 64; j++) begin
                    int c;
                    logic me;
                    logic pt;
                    c = 1 << k;
                    me = x[j];
                    pt = x[j ^ c];
                    if ((j & c) == 0) y[j] = im[{1'b0, me, pt}];
                    else              y[j] = im[{1'b1, pt, me}];
                end
                x = y;
            end
        end
        return x;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [4:0] s, input logic [63:0] v, input logic [63:0] sh,
                         input logic [7:0] im, input logic inv);
        @(negedge clk);
        src_sel = s; src_val = v; shamt = sh; imm = im; invert = inv; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin : watchdog
        #(5 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] lfsr;
        logic [63:0] held;
        lfsr = 64'h9E37_79B9_7F4A_7C15;

        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 out_valid in reset", {63'd0, out_valid}, 64'd0);
        check("R11 result in reset", result, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            string tag;
            apply(VECS[i].sel, VECS[i].val, VECS[i].sh, VECS[i].im, VECS[i].inv);
            tag = $sformatf("R%0d vector %0d", VECS[i].req, i);
            check(tag, result, VECS[i].exp);
        end

        // R10: latency and valid
        apply(5'd4, 64'hCAFE_F00D_1234_5678, 64'd0, 8'h00, 1'b0);
        check("R10 out_valid after one edge", {63'd0, out_valid}, 64'd1);
        check("R2 passthrough", result, 64'hCAFE_F00D_1234_5678);
        held = result;

        // R10: idle cycle with changed inputs holds result
        src_sel = 5'd7; src_val = 64'h1; shamt = 64'd63; imm = 8'hEE;
        @(negedge clk);
        check("R10 out_valid low when idle", {63'd0, out_valid}, 64'd0);
        check("R10 result held when idle", result, held);

        // R4 R5: pseudo-random against the model
        for (int i = 0; i < 300; i++) begin
            logic [4:0]  s;
            logic [63:0] v;
            logic [63:0] sh;
            logic [7:0]  im;
            logic        inv;
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 7); lfsr = lfsr ^ (lfsr << 17);
            v = lfsr;
            s = (i % 5 == 0) ? 5'd0 : lfsr[4:0] | 5'd1;
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 7); lfsr = lfsr ^ (lfsr << 17);
            sh = lfsr;
            im = lfsr[15:8];
            inv = lfsr[20];
            apply(s, v, sh, im, inv);
            check($sformatf("R4 R5 random %0d", i), result, model(s, v, sh, im, inv));
        end

        // R11: reset again clears result
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 result after reset", result, 64'd0);

        done = 1'b1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule